// File: doc/BRIEF.md
# CD Sector Buffer Write Controller

This block takes a stream of raw disc-sector bytes, each presented with its position inside the sector and a one-cycle strobe, and stores them in a circular byte buffer. A 16-bit write address steps forward by one after each stored byte. Only the low address bits select a buffer location, so the buffer wraps on its own. The buffer holds 2^BUF_AW bytes; a full 16 KB buffer uses BUF_AW = 14, and the address wraps modulo 0x4000.

When the byte at the sync position (offset 12) arrives, the header is marked stale. In store mode, the start address of the sector just finished is then recorded in a block pointer, and a decode timer starts. When the timer expires, the four bytes found in the buffer at the block pointer are copied into the header registers. The block then marks the header valid and drops an active-low decode-done status bit.

A second mode only watches the stream: it copies offsets 12 to 15 straight into the header registers and stores nothing. Host writes can set either byte of the write address or of the block pointer. A write to the pointer's high byte also starts a decode.

Top module: `cdbuf_wr_ctrl`

## Requirements
- R1: After reset, wr_addr and blk_ptr are 0, hdr_bytes is 0, hdr_invalid is 1, dec_irq_n is 1 and dec_irq is 0.
- R2: With dec_en=1 and wr_req=1 (store mode), each strobed byte is written to buffer location wr_addr mod 2^BUF_AW. wr_addr then increments by one as a 16-bit value, with carry from the low byte into the high byte.
- R3: Outside store mode, a strobed byte changes neither wr_addr nor the buffer, and in idle mode (dec_en=0) it does not change hdr_bytes.
- R4: A strobe with in_ofs = 12 sets hdr_invalid to 1 in every mode, one cycle later.
- R5: In store mode, a strobe with in_ofs = 12 loads blk_ptr with wr_addr minus SECTOR_LEN (mod 2^16). Here wr_addr is the value before this byte's increment. The same strobe starts a decode.
- R6: A decode completes SECTOR_LEN x DEC_MULT x STEP_CLKS clocks after its start (defaults 2352 x 4 x 24). The header registers are filled a few cycles later; at that point dec_irq_n drops to 0 and hdr_invalid drops to 0.
- R7: On completion, hdr_bytes[8k+7:8k] (k = 0..3) holds the buffer byte at (blk_ptr + k) mod 2^BUF_AW, wrapping past the buffer end.
- R8: With dec_en=1 and wr_req=0 (monitor mode), a strobe with in_ofs from 12 to 15 places the byte in hdr_bytes lane in_ofs-12, and no decode starts.
- R9: Host write with host_sel 0/1 sets the low/high byte of wr_addr. host_sel 2/3 sets the low/high byte of blk_ptr, and a high-byte write also starts a decode.
- R10: Each decode start sets dec_irq_n back to 1 and restarts the full decode delay, even while a decode is pending.
- R11: dec_irq equals irq_en AND NOT dec_irq_n, registered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe for one sector byte |
| in_ofs | input | OFS_W | Position of the byte within its sector |
| in_byte | input | 8 | Sector byte |
| dec_en | input | 1 | Decode enable control bit |
| wr_req | input | 1 | Buffer write request control bit |
| irq_en | input | 1 | Decode-done interrupt enable |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | 0 addr low, 1 addr high, 2 pointer low, 3 pointer high |
| host_wdata | input | 8 | Host write data |
| wr_addr | output | 16 | Current buffer write address |
| blk_ptr | output | 16 | Start address of the last completed block |
| hdr_bytes | output | 32 | Four header registers, register 0 in bits 7:0 |
| hdr_invalid | output | 1 | 1 while the header registers are stale |
| dec_irq_n | output | 1 | Decode-done status, active low |
| dec_irq | output | 1 | Decode-done interrupt |

## Verification
If the write address steps or carries wrongly, the error stays hidden in the buffer until the next decode. It then appears as header bytes that do not match what was streamed, roughly one decode delay after the following sync byte. A wrong block pointer shows on blk_ptr in the cycle after the sync strobe. A timer that runs short, runs long or fails to restart shows as dec_irq_n falling outside the window that follows the last decode start. A broken header fetch shows as a wrong lane or a wrong wrap, which is why one directed sector places the header across the buffer end.

// File: rtl/cdbuf_pkg.sv
package cdbuf_pkg;
  typedef enum logic [1:0] {
    HSEL_WA_LO = 2'd0,
    HSEL_WA_HI = 2'd1,
    HSEL_PT_LO = 2'd2,
    HSEL_PT_HI = 2'd3
  } hsel_e;
  localparam int HDR_BYTES = 4;
endpackage

// File: rtl/cdbuf_ram.sv
module cdbuf_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cdbuf_dec_timer.sv
module cdbuf_dec_timer #(
  parameter int TOTAL_STEPS = 9408,
  parameter int STEP_CLKS   = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int SW = $clog2(TOTAL_STEPS + 1);
  localparam int PW = $clog2(STEP_CLKS + 1);
  localparam logic [SW-1:0] STEPS_INIT = SW'(TOTAL_STEPS);
  localparam logic [PW-1:0] PRE_INIT   = PW'(STEP_CLKS - 1);

  logic          busy;
  logic [SW-1:0] steps;
  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      steps <= '0;
      pre   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        steps <= STEPS_INIT;
        pre   <= PRE_INIT;
      end else if (busy) begin
        if (pre == '0) begin
          pre   <= PRE_INIT;
          steps <= steps - SW'(1);
          if (steps == SW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          pre <= pre - PW'(1);
        end
      end
    end
  end

  // R6: completion only follows a running count that was not just restarted
  a_r6_done_from_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !$past(start)));
  // R10: a start always leaves the full count loaded
  a_r10_restart_full: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && steps == STEPS_INIT && !done));
endmodule

// File: rtl/cdbuf_hdr_fetch.sv
module cdbuf_hdr_fetch #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] base_in,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          hdr_we,
  output logic [1:0]    hdr_idx,
  output logic [7:0]    hdr_wdata,
  output logic          fin
);
  logic          active;
  logic [1:0]    idx;
  logic [AW-1:0] base;
  logic          vq;
  logic [1:0]    iq;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
      vq     <= 1'b0;
      iq     <= '0;
    end else begin
      vq <= active;
      iq <= idx;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
        base   <= base_in;
      end else if (active) begin
        idx <= idx + 2'd1;
        if (idx == 2'd3) active <= 1'b0;
      end
    end
  end

  assign rd_addr   = base + AW'(idx);
  assign hdr_we    = vq;
  assign hdr_idx   = iq;
  assign hdr_wdata = rd_data;
  assign fin       = vq && (iq == 2'd3);

  // R7: header lanes are filled in order, each after the previous lane
  a_r7_lane_order: assert property (@(posedge clk) disable iff (rst)
    (vq && iq != 2'd0) |-> ($past(vq) && $past(iq) == iq - 2'd1));
endmodule

// File: rtl/cdbuf_wr_ctrl.sv
module cdbuf_wr_ctrl
  import cdbuf_pkg::*;
#(
  parameter int BUF_AW     = 12,
  parameter int OFS_W      = 12,
  parameter int SECTOR_LEN = 2352,
  parameter int SYNC_OFS   = 12,
  parameter int DEC_MULT   = 4,
  parameter int STEP_CLKS  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OFS_W-1:0] in_ofs,
  input  logic [7:0]       in_byte,
  input  logic             dec_en,
  input  logic             wr_req,
  input  logic             irq_en,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic [7:0]       host_wdata,
  output logic [15:0]      wr_addr,
  output logic [15:0]      blk_ptr,
  output logic [31:0]      hdr_bytes,
  output logic             hdr_invalid,
  output logic             dec_irq_n,
  output logic             dec_irq
);
  localparam logic [15:0]      SECT_SUB = 16'(SECTOR_LEN);
  localparam logic [OFS_W-1:0] SYNC_V   = OFS_W'(SYNC_OFS);

  logic             store_mode, mon_mode, sync_hit;
  logic             hw_wa, hw_pt_lo, hw_pt_hi, dec_start;
  logic [OFS_W-1:0] mon_rel;
  logic             mon_hit;
  logic             dec_done, ld_we, ld_fin;
  logic [1:0]       ld_idx;
  logic [7:0]       ld_data, rd_data;
  logic [BUF_AW-1:0] rd_addr;

  assign store_mode = dec_en & wr_req;
  assign mon_mode   = dec_en & ~wr_req;
  assign sync_hit   = in_valid && (in_ofs == SYNC_V);
  assign hw_wa      = host_we && (hsel_e'(host_sel) == HSEL_WA_LO || hsel_e'(host_sel) == HSEL_WA_HI);
  assign hw_pt_lo   = host_we && hsel_e'(host_sel) == HSEL_PT_LO;
  assign hw_pt_hi   = host_we && hsel_e'(host_sel) == HSEL_PT_HI;
  assign dec_start  = (sync_hit && store_mode) || hw_pt_hi;
  assign mon_rel    = in_ofs - SYNC_V;
  assign mon_hit    = in_valid && mon_mode && (mon_rel < OFS_W'(HDR_BYTES));

  cdbuf_ram #(.AW(BUF_AW), .DW(8)) u_ram (
    .clk   (clk),
    .we    (in_valid && store_mode),
    .waddr (wr_addr[BUF_AW-1:0]),
    .wdata (in_byte),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  cdbuf_dec_timer #(.TOTAL_STEPS(SECTOR_LEN * DEC_MULT), .STEP_CLKS(STEP_CLKS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (dec_start),
    .done  (dec_done)
  );

  cdbuf_hdr_fetch #(.AW(BUF_AW)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .go        (dec_done),
    .base_in   (blk_ptr[BUF_AW-1:0]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .hdr_we    (ld_we),
    .hdr_idx   (ld_idx),
    .hdr_wdata (ld_data),
    .fin       (ld_fin)
  );

  // write address: host write wins over the stream increment
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
    end else if (host_we && hsel_e'(host_sel) == HSEL_WA_LO) begin
      wr_addr[7:0] <= host_wdata;
    end else if (host_we && hsel_e'(host_sel) == HSEL_WA_HI) begin
      wr_addr[15:8] <= host_wdata;
    end else if (in_valid && store_mode) begin
      wr_addr <= wr_addr + 16'd1;
    end
  end

  // block pointer: sector boundary wins over host writes
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_ptr <= '0;
    end else if (sync_hit && store_mode) begin
      blk_ptr <= wr_addr - SECT_SUB;
    end else if (hw_pt_lo) begin
      blk_ptr[7:0] <= host_wdata;
    end else if (hw_pt_hi) begin
      blk_ptr[15:8] <= host_wdata;
    end
  end

  // header registers: buffer fetch has priority over monitor capture
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_bytes <= '0;
    end else if (ld_we) begin
      hdr_bytes[{ld_idx, 3'b000} +: 8] <= ld_data;
    end else if (mon_hit) begin
      hdr_bytes[{mon_rel[1:0], 3'b000} +: 8] <= in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_invalid <= 1'b1;
      dec_irq_n   <= 1'b1;
      dec_irq     <= 1'b0;
    end else begin
      if (sync_hit)    hdr_invalid <= 1'b1;
      else if (ld_fin) hdr_invalid <= 1'b0;
      if (dec_start)   dec_irq_n <= 1'b1;
      else if (ld_fin) dec_irq_n <= 1'b0;
      dec_irq <= irq_en & ~dec_irq_n;
    end
  end

  // R2: a stored byte advances the 16-bit write address by exactly one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid && store_mode && !hw_wa) |=> (wr_addr == $past(wr_addr) + 16'd1));
  // R3: without a stored byte or host write the address holds
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && store_mode) && !hw_wa) |=> $stable(wr_addr));
  // R4: the sync byte always marks the header stale
  a_r4_sync_stale: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> hdr_invalid);
  // R5: pointer lands one sector behind the address seen at the sync byte
  a_r5_ptr_back: assert property (@(posedge clk) disable iff (rst)
    (sync_hit && store_mode) |=> (blk_ptr == $past(wr_addr) - SECT_SUB));
  // R10: a decode start re-arms the status bit
  a_r10_rearm: assert property (@(posedge clk) disable iff (rst)
    dec_start |=> dec_irq_n);
  // R11: interrupt follows enable and status one cycle later
  a_r11_irq: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (dec_irq == $past(irq_en && !dec_irq_n)));
endmodule

// File: tb/cdbuf_wr_ctrl_tb.sv
module cdbuf_wr_ctrl_tb;
  localparam int AW    = 8;
  localparam int SL    = 32;
  localparam int MULT  = 4;
  localparam int STEP  = 3;
  localparam int DELAY = SL * MULT * STEP;
  localparam int MASK  = (1 << AW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_ofs = '0;
  logic [7:0]  in_byte = '0;
  logic        dec_en = 1'b0, wr_req = 1'b0, irq_en = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] wr_addr, blk_ptr;
  logic [31:0] hdr_bytes;
  logic        hdr_invalid, dec_irq_n, dec_irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0]  shadow [1 << AW];
  logic [15:0] m_wa = '0;
  logic [15:0] m_ptr = '0;
  logic [31:0] m_hdr = '0;

  always #5 clk = ~clk;

  cdbuf_wr_ctrl #(.BUF_AW(AW), .OFS_W(12), .SECTOR_LEN(SL), .SYNC_OFS(12),
                  .DEC_MULT(MULT), .STEP_CLKS(STEP)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ofs(in_ofs), .in_byte(in_byte),
    .dec_en(dec_en), .wr_req(wr_req), .irq_en(irq_en), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata), .wr_addr(wr_addr), .blk_ptr(blk_ptr),
    .hdr_bytes(hdr_bytes), .hdr_invalid(hdr_invalid), .dec_irq_n(dec_irq_n), .dec_irq(dec_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_from_buf(input logic [15:0] p);
    logic [31:0] h;
    for (int k = 0; k < 4; k++) h[8*k +: 8] = shadow[(int'(p) + k) & MASK];
    return h;
  endfunction

  task automatic send(input int ofs, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_ofs = 12'(ofs); in_byte = b;
    if (dec_en && wr_req) begin
      if (ofs == 12) m_ptr = m_wa - 16'(SL);
      shadow[int'(m_wa) & MASK] = b;
      m_wa = m_wa + 16'd1;
    end else if (dec_en && ofs >= 12 && ofs <= 15) begin
      m_hdr[8*(ofs-12) +: 8] = b;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic host(input int sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = 2'(sel); host_wdata = d;
    case (sel)
      0: m_wa[7:0]   = d;
      1: m_wa[15:8]  = d;
      2: m_ptr[7:0]  = d;
      default: m_ptr[15:8] = d;
    endcase
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_dec(output int n);
    n = 0;
    while (dec_irq_n !== 1'b0 && n < DELAY + 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  // full sector from offset 0 then next sector up to the sync byte
  task automatic stream_sector(input logic [15:0] start);
    host(0, start[7:0]);
    host(1, start[15:8]);
    dec_en = 1'b1; wr_req = 1'b1;
    for (int i = 0; i < SL; i++) send(i, 8'($urandom));
    for (int i = 0; i <= 12; i++) send(i, 8'($urandom));
  endtask

  task automatic check_decode(input string req);
    int n;
    wait_dec(n);
    vectors++;
    if (n < DELAY || n > DELAY + 12) begin
      fails++;
      $display("FAIL %s (R6 delay) actual=%0d expected=%0d..%0d", req, n, DELAY, DELAY + 12);
    end
    chk({req, " R6 dec_irq_n"}, 32'(dec_irq_n), 32'd0);
    chk({req, " R6 hdr_invalid"}, 32'(hdr_invalid), 32'd0);
    chk({req, " R7 header"}, hdr_bytes, hdr_from_buf(m_ptr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] keep;
    void'($urandom(32'd1234));
    for (int i = 0; i <= MASK; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 wr_addr", 32'(wr_addr), 32'd0);
    chk("R1 blk_ptr", 32'(blk_ptr), 32'd0);
    chk("R1 hdr", hdr_bytes, 32'd0);
    chk("R1 hdr_invalid", 32'(hdr_invalid), 32'd1);
    chk("R1 dec_irq_n", 32'(dec_irq_n), 32'd1);
    chk("R1 dec_irq", 32'(dec_irq), 32'd0);

    // R9 host address bytes, R2 carry across the low byte
    host(0, 8'hFE); host(1, 8'h12);
    chk("R9 wr_addr host", 32'(wr_addr), 32'h12FE);
    dec_en = 1'b1; wr_req = 1'b1;
    for (int i = 0; i < 4; i++) send(20 + i, 8'(8'hA0 + i));
    chk("R2 carry", 32'(wr_addr), 32'h1302);

    // directed sector whose header straddles the buffer end (R5, R7)
    stream_sector(16'h01F2);
    chk("R4 stale at sync", 32'(hdr_invalid), 32'd1);
    chk("R5 blk_ptr", 32'(blk_ptr), 32'(m_ptr));
    chk("R10 rearm", 32'(dec_irq_n), 32'd1);
    check_decode("R7 wrap sector");

    // R11 interrupt
    irq_en = 1'b1;
    @(negedge clk);
    chk("R11 irq on", 32'(dec_irq), 32'd1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R11 irq off", 32'(dec_irq), 32'd0);

    // R10 restart of a pending decode
    send(12, 8'h55);
    repeat (100) @(negedge clk);
    chk("R10 still pending", 32'(dec_irq_n), 32'd1);
    send(12, 8'h66);
    check_decode("R10 restart");

    // R8 monitor mode capture, no buffer write, no decode
    dec_en = 1'b1; wr_req = 1'b0;
    for (int i = 12; i < 16; i++) send(i, 8'($urandom));
    chk("R8 monitor hdr", hdr_bytes, m_hdr);
    chk("R3 monitor wr_addr", 32'(wr_addr), 32'(m_wa));
    repeat (DELAY + 20) @(negedge clk);
    chk("R8 no decode", 32'(dec_irq_n), 32'd0);
    chk("R8 hdr kept", hdr_bytes, m_hdr);

    // R3/R4 idle mode
    dec_en = 1'b0; wr_req = 1'b1;
    keep = hdr_bytes;
    for (int i = 10; i < 18; i++) send(i, 8'($urandom));
    chk("R3 idle wr_addr", 32'(wr_addr), 32'(m_wa));
    chk("R3 idle hdr", hdr_bytes, keep);
    chk("R4 idle stale", 32'(hdr_invalid), 32'd1);

    // R9 host pointer write starts a decode on bytes already stored
    host(2, 8'(m_wa - 16'd10));
    host(3, 8'((m_wa - 16'd10) >> 8));
    chk("R9 blk_ptr", 32'(blk_ptr), 32'(m_ptr));
    chk("R9 rearm", 32'(dec_irq_n), 32'd1);
    check_decode("R9 host decode");

    // random sectors
    for (int r = 0; r < 8; r++) begin
      stream_sector(16'($urandom));
      chk("R5 random blk_ptr", 32'(blk_ptr), 32'(m_ptr));
      check_decode("R7 random sector");
      chk("R2 random wr_addr", 32'(wr_addr), 32'(m_wa));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule